// File: doc/BRIEF.md
# PCI Power State Controller

This block follows the power state of a bus-attached network controller. There are five states: active before initialization, active after initialization, hot suspend, cold suspend and unpowered. It watches five inputs: the active-low bus reset pin, the two-bit power-state field that the host writes, an auxiliary-supply detect, a main-supply power-good, and a one-cycle pulse from software that marks the end of initialization. From these it decides each transition. The outputs are registered and drive the side effects of each state: a PHY reset pulse, a PHY power-down level, a clock-disable level for the PLL and the clocks derived from it, and an enable for memory and I/O accesses. Configuration accesses are never gated.

The three asynchronous pins (bus reset, auxiliary detect and power-good) pass through a synchronizer with `SYNC_STAGES` flops. A further registered copy of each is kept for edge detection. The host field is already in the block clock domain, so it is compared with its value one cycle earlier to find writes. The block makes at most one transition per clock. Supply loss has the highest priority, then the bus-reset edge, then the host field write. A host write that leaves hot suspend also raises a one-cycle reset pulse.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the state is active-uninitialized with `state_o` = 0, `mem_io_en` = 1, and `clk_dis`, `phy_pd`, `phy_rst_req`, `d3_exit_rst` and `pm_status` all 0. The state codes are: active-uninitialized 0, active-initialized 1, hot suspend 2, cold suspend 3, unpowered 4.
- R2: In active-uninitialized, an `init_done` pulse moves the state to active-initialized if synchronized bus reset is deasserted and power-good is high.
- R3: In active-initialized, a host write of `pm_field` from 00 on one cycle to 11 on the next moves the state to hot suspend, provided bus reset is deasserted and power-good is high. In hot suspend `clk_dis` = 1, `mem_io_en` = 0 and `pm_status` = 11.
- R4: On the move into hot suspend, `phy_rst_req` pulses for one cycle and `phy_pd` rises only when `pme_en` is 0. When `pme_en` is 1, neither happens and `phy_pd` stays 0 for the whole suspend.
- R5: In active-initialized, a falling edge of bus reset while `pm_field` is 00 moves the state to active-uninitialized.
- R6: A falling edge of power-good while auxiliary detect is 1 moves the state from either active state or from hot suspend to cold suspend. That move pulses `phy_rst_req` once and sets `phy_pd`.
- R7: A falling edge of power-good while auxiliary detect is 0 moves the state to unpowered. This includes both supplies falling together. Unpowered holds `phy_pd` = 1 and `mem_io_en` = 0.
- R8: In hot suspend, a host write of `pm_field` from 11 to 00 moves the state to active-uninitialized, provided bus reset is deasserted and power-good is high. At the same time `d3_exit_rst` is high for exactly one cycle.
- R9: In hot suspend, a falling edge of bus reset leaves the state unchanged. A power-good fall in hot suspend goes to cold suspend whatever the level of bus reset.
- R10: Cold suspend moves to unpowered when auxiliary detect drops. Cold suspend and unpowered both return to active-uninitialized on a rising edge of power-good.
- R11: When a power-good fall and a host field write take effect on the same clock, the power-good fall wins.
- R12: A change on a synchronized pin takes effect at the (`SYNC_STAGES`+1)-th rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_n | input | 1 | Bus reset pin, active low, asynchronous |
| pm_field | input | 2 | Power-state field written by the host, 00 = full power, 11 = suspend |
| pme_en | input | 1 | Wake-event enable bit |
| aux_det | input | 1 | Auxiliary supply present, asynchronous |
| pwr_good | input | 1 | Main supply good, asynchronous |
| init_done | input | 1 | One-cycle pulse marking the end of initialization |
| phy_rst_req | output | 1 | One-cycle PHY reset request |
| phy_pd | output | 1 | PHY general power-down request |
| clk_dis | output | 1 | PLL and derived clock disable |
| mem_io_en | output | 1 | Memory and I/O access enable |
| d3_exit_rst | output | 1 | One-cycle reset pulse on leaving hot suspend |
| state_o | output | 3 | Current state code |
| pm_status | output | 2 | Power-state field readback |

## Verification
A wrong internal state shows up at the ports on the very next clock, because the state code, the clock disable, the access enable and the readback field all come from the same registered next state. A bench that compares them every cycle catches a bad transition within one cycle. Side effects are harder to see, because they show only as pulses. A PHY reset that is missing or extra, or a wrong power-down level after a suspend entry that depends on the wake enable, is visible only in the cycle of the move. For that reason the bench counts pulses as well as comparing levels. Errors in the synchronizer latency appear as a transition one edge early or one edge late relative to the pin change.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  localparam int PS_W = 3;

  typedef enum logic [PS_W-1:0] {
    PS_D0U    = 3'd0,
    PS_D0A    = 3'd1,
    PS_D3HOT  = 3'd2,
    PS_D3COLD = 3'd3,
    PS_G3     = 3'd4
  } pwr_state_e;

  localparam logic [1:0] FLD_FULL = 2'b00;
  localparam logic [1:0] FLD_SUSP = 2'b11;

  // Pin index into the synchronized vector
  localparam int PIN_RSTN = 0;
  localparam int PIN_AUX  = 1;
  localparam int PIN_PG   = 2;
  localparam int PIN_N    = 3;
endpackage

// File: rtl/pwr_sync_edge.sv
module pwr_sync_edge #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      if (STAGES == 1) begin : g_one
        always_ff @(posedge clk) begin
          if (rst) chain_q <= RST_VAL[b];
          else     chain_q <= din[b];
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (rst) chain_q <= {STAGES{RST_VAL[b]}};
          else     chain_q <= {chain_q[STAGES-2:0], din[b]};
        end
      end
      assign lvl[b] = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = prev_q & ~lvl;
endmodule

// File: rtl/pwr_state_next.sv
module pwr_state_next
  import pwr_state_pkg::*;
(
  input  pwr_state_e cur,
  input  logic       rstn_lvl,
  input  logic       rstn_fall,
  input  logic       aux_lvl,
  input  logic       pg_lvl,
  input  logic       pg_rise,
  input  logic       pg_fall,
  input  logic [1:0] fld,
  input  logic [1:0] fld_prev,
  input  logic       pme_en,
  input  logic       init_done,
  output pwr_state_e nxt,
  output logic       phy_rst_pulse,
  output logic       pd_on_entry,
  output logic       exit_pulse
);
  logic host_ok;
  logic wr_to_susp;
  logic wr_to_full;

  assign host_ok    = rstn_lvl & pg_lvl;
  assign wr_to_susp = (fld_prev == FLD_FULL) && (fld == FLD_SUSP);
  assign wr_to_full = (fld_prev == FLD_SUSP) && (fld == FLD_FULL);

  always_comb begin
    nxt           = cur;
    phy_rst_pulse = 1'b0;
    pd_on_entry   = 1'b0;
    exit_pulse    = 1'b0;
    unique case (cur)
      PS_D0U: begin
        if (pg_fall) begin
          nxt           = aux_lvl ? PS_D3COLD : PS_G3;
          phy_rst_pulse = aux_lvl;
        end else if (init_done && host_ok) begin
          nxt = PS_D0A;
        end
      end
      PS_D0A: begin
        if (pg_fall) begin
          nxt           = aux_lvl ? PS_D3COLD : PS_G3;
          phy_rst_pulse = aux_lvl;
        end else if (rstn_fall && (fld == FLD_FULL)) begin
          nxt = PS_D0U;
        end else if (wr_to_susp && host_ok) begin
          nxt           = PS_D3HOT;
          phy_rst_pulse = ~pme_en;
          pd_on_entry   = ~pme_en;
        end
      end
      PS_D3HOT: begin
        if (pg_fall) begin
          nxt           = aux_lvl ? PS_D3COLD : PS_G3;
          phy_rst_pulse = aux_lvl;
        end else if (wr_to_full && host_ok) begin
          nxt        = PS_D0U;
          exit_pulse = 1'b1;
        end
      end
      PS_D3COLD: begin
        if (!aux_lvl)     nxt = PS_G3;
        else if (pg_rise) nxt = PS_D0U;
      end
      PS_G3: begin
        if (pg_rise) nxt = PS_D0U;
      end
      default: nxt = PS_D0U;
    endcase
  end
endmodule

// File: rtl/pwr_out_reg.sv
module pwr_out_reg
  import pwr_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pwr_state_e nxt,
  input  logic       phy_rst_pulse,
  input  logic       pd_on_entry,
  input  logic       exit_pulse,
  output pwr_state_e state_q,
  output logic       phy_rst_req,
  output logic       phy_pd,
  output logic       clk_dis,
  output logic       mem_io_en,
  output logic       d3_exit_rst,
  output logic [1:0] pm_status
);
  logic nxt_active;
  logic nxt_susp;

  assign nxt_active = (nxt == PS_D0U) || (nxt == PS_D0A);
  assign nxt_susp   = (nxt == PS_D3HOT) || (nxt == PS_D3COLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PS_D0U;
      phy_rst_req <= 1'b0;
      phy_pd      <= 1'b0;
      clk_dis     <= 1'b0;
      mem_io_en   <= 1'b1;
      d3_exit_rst <= 1'b0;
      pm_status   <= FLD_FULL;
    end else begin
      state_q     <= nxt;
      phy_rst_req <= phy_rst_pulse;
      d3_exit_rst <= exit_pulse;
      clk_dis     <= ~nxt_active;
      mem_io_en   <= nxt_active;
      pm_status   <= nxt_susp ? FLD_SUSP : FLD_FULL;
      unique case (nxt)
        PS_D0U, PS_D0A:    phy_pd <= 1'b0;
        PS_D3COLD, PS_G3:  phy_pd <= 1'b1;
        PS_D3HOT:          if (state_q != PS_D3HOT) phy_pd <= pd_on_entry;
        default:           phy_pd <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_rst_n,
  input  logic [1:0] pm_field,
  input  logic       pme_en,
  input  logic       aux_det,
  input  logic       pwr_good,
  input  logic       init_done,
  output logic       phy_rst_req,
  output logic       phy_pd,
  output logic       clk_dis,
  output logic       mem_io_en,
  output logic       d3_exit_rst,
  output logic [2:0] state_o,
  output logic [1:0] pm_status
);
  logic [PIN_N-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  logic [1:0]       fld_prev_q;
  pwr_state_e       state_q, nxt;
  logic             phy_rst_pulse, pd_on_entry, exit_pulse;

  assign pin_raw[PIN_RSTN] = bus_rst_n;
  assign pin_raw[PIN_AUX]  = aux_det;
  assign pin_raw[PIN_PG]   = pwr_good;

  pwr_sync_edge #(
    .W      (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL({PIN_N{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_raw),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) fld_prev_q <= FLD_FULL;
    else     fld_prev_q <= pm_field;
  end

  pwr_state_next u_next (
    .cur          (state_q),
    .rstn_lvl     (pin_lvl[PIN_RSTN]),
    .rstn_fall    (pin_fall[PIN_RSTN]),
    .aux_lvl      (pin_lvl[PIN_AUX]),
    .pg_lvl       (pin_lvl[PIN_PG]),
    .pg_rise      (pin_rise[PIN_PG]),
    .pg_fall      (pin_fall[PIN_PG]),
    .fld          (pm_field),
    .fld_prev     (fld_prev_q),
    .pme_en       (pme_en),
    .init_done    (init_done),
    .nxt          (nxt),
    .phy_rst_pulse(phy_rst_pulse),
    .pd_on_entry  (pd_on_entry),
    .exit_pulse   (exit_pulse)
  );

  pwr_out_reg u_out (
    .clk          (clk),
    .rst          (rst),
    .nxt          (nxt),
    .phy_rst_pulse(phy_rst_pulse),
    .pd_on_entry  (pd_on_entry),
    .exit_pulse   (exit_pulse),
    .state_q      (state_q),
    .phy_rst_req  (phy_rst_req),
    .phy_pd       (phy_pd),
    .clk_dis      (clk_dis),
    .mem_io_en    (mem_io_en),
    .d3_exit_rst  (d3_exit_rst),
    .pm_status    (pm_status)
  );

  assign state_o = state_q;
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk (
  input logic       clk,
  input logic       rst,
  input logic       phy_rst_req,
  input logic       phy_pd,
  input logic       clk_dis,
  input logic       mem_io_en,
  input logic       d3_exit_rst,
  input logic [2:0] state_o,
  input logic [1:0] pm_status
);
  assert_hot_gating_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2) |-> (!mem_io_en && clk_dis && pm_status == 2'b11));

  assert_active_open_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1) |-> (mem_io_en && !clk_dis && !phy_pd));

  assert_phy_rst_target_R6: assert property (@(posedge clk) disable iff (rst)
    phy_rst_req |-> (state_o == 3'd2 || state_o == 3'd3));

  assert_cold_pd_R6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3) |-> phy_pd);

  assert_unpowered_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4) |-> (phy_pd && !mem_io_en));

  assert_exit_origin_R8: assert property (@(posedge clk) disable iff (rst)
    d3_exit_rst |-> (state_o == 3'd0 && $past(state_o) == 3'd2));

  assert_exit_single_R8: assert property (@(posedge clk) disable iff (rst)
    d3_exit_rst |=> !d3_exit_rst);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd4);
endmodule

bind pwr_state_ctrl pwr_state_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .phy_rst_req(phy_rst_req),
  .phy_pd     (phy_pd),
  .clk_dis    (clk_dis),
  .mem_io_en  (mem_io_en),
  .d3_exit_rst(d3_exit_rst),
  .state_o    (state_o),
  .pm_status  (pm_status)
);

// File: tb/tb_pwr_state_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_state_ctrl;
  localparam int STG = 2;
  localparam int D0U = 0, D0A = 1, D3H = 2, D3C = 3, G3 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_rst_n = 1'b1;
  logic [1:0] pm_field = 2'b00;
  logic pme_en = 1'b1;
  logic aux_det = 1'b1;
  logic pwr_good = 1'b1;
  logic init_done = 1'b0;
  logic phy_rst_req, phy_pd, clk_dis, mem_io_en, d3_exit_rst;
  logic [2:0] state_o;
  logic [1:0] pm_status;

  int n_tests = 0;
  int n_fail  = 0;
  int n_prst  = 0;
  int n_exit  = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pwr_state_ctrl #(.SYNC_STAGES(STG)) dut (
    .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .pm_field(pm_field),
    .pme_en(pme_en), .aux_det(aux_det), .pwr_good(pwr_good),
    .init_done(init_done), .phy_rst_req(phy_rst_req), .phy_pd(phy_pd),
    .clk_dis(clk_dis), .mem_io_en(mem_io_en), .d3_exit_rst(d3_exit_rst),
    .state_o(state_o), .pm_status(pm_status)
  );

  // Behavioural reference model
  bit q_pg[$], q_ax[$], q_rn[$];
  bit p_pg, p_rn, p_ax;
  int m_state;
  bit m_prst, m_pd, m_exit;
  logic [1:0] m_fprev;

  task automatic model_reset();
    q_pg = {}; q_ax = {}; q_rn = {};
    for (int i = 0; i < STG; i++) begin
      q_pg.push_back(1'b1); q_ax.push_back(1'b1); q_rn.push_back(1'b1);
    end
    p_pg = 1; p_rn = 1; p_ax = 1;
    m_state = D0U; m_prst = 0; m_pd = 0; m_exit = 0; m_fprev = 2'b00;
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      bit pg, ax, rn, pgf, pgr, rnf, ok;
      int ns;
      pg = q_pg[STG-1]; ax = q_ax[STG-1]; rn = q_rn[STG-1];
      pgf = p_pg && !pg; pgr = !p_pg && pg; rnf = p_rn && !rn;
      ok = rn && pg;
      ns = m_state; m_prst = 0; m_exit = 0;
      if ((m_state == D0U || m_state == D0A || m_state == D3H) && pgf) begin
        ns = ax ? D3C : G3;
        m_prst = ax;
      end else if (m_state == D0U) begin
        if (init_done && ok) ns = D0A;
      end else if (m_state == D0A) begin
        if (rnf && pm_field == 2'b00) ns = D0U;
        else if (m_fprev == 2'b00 && pm_field == 2'b11 && ok) begin
          ns = D3H; m_prst = !pme_en; m_pd = !pme_en;
        end
      end else if (m_state == D3H) begin
        if (m_fprev == 2'b11 && pm_field == 2'b00 && ok) begin
          ns = D0U; m_exit = 1;
        end
      end else if (m_state == D3C) begin
        if (!ax) ns = G3;
        else if (pgr) ns = D0U;
      end else if (m_state == G3) begin
        if (pgr) ns = D0U;
      end
      if (ns == D0U || ns == D0A) m_pd = 0;
      if (ns == D3C || ns == G3) m_pd = 1;
      m_state = ns;
      p_pg = pg; p_ax = ax; p_rn = rn;
      q_pg.push_front(pwr_good); void'(q_pg.pop_back());
      q_ax.push_front(aux_det);  void'(q_ax.pop_back());
      q_rn.push_front(bus_rst_n); void'(q_rn.pop_back());
      m_fprev = pm_field;
    end
  end

  // Per-cycle comparison against model, plus pulse counters
  always @(negedge clk) begin
    if (!rst) begin
      logic [10:0] act, exp;
      bit act_ok;
      act = {state_o, pm_status, phy_rst_req, phy_pd, clk_dis, mem_io_en, d3_exit_rst, 1'b0};
      exp = {m_state[2:0], ((m_state == D3H || m_state == D3C) ? 2'b11 : 2'b00),
             m_prst, m_pd, !(m_state == D0U || m_state == D0A),
             (m_state == D0U || m_state == D0A), m_exit, 1'b0};
      act_ok = (act == exp);
      n_tests++;
      if (!act_ok) begin
        n_fail++;
        $display("FAIL %s model compare: actual %b expected %b at %0t", cur_req, act, exp, $time);
      end
      if (phy_rst_req) n_prst++;
      if (d3_exit_rst) n_exit++;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_init();
    init_done = 1'b1; cyc(1); init_done = 1'b0; cyc(1);
  endtask

  task automatic to_active();
    pulse_init();
  endtask

  initial begin
    #1500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    cur_req = "R1";
    chk("R1", state_o, D0U, "reset state");
    chk("R1", {mem_io_en, clk_dis, phy_pd, phy_rst_req, d3_exit_rst}, 5'b10000, "reset outputs");
    chk("R1", pm_status, 0, "reset readback");

    cur_req = "R2"; to_active();
    chk("R2", state_o, D0A, "init done to active");

    // Hot suspend with wake enable set
    cur_req = "R3"; base = n_prst; pme_en = 1'b1;
    pm_field = 2'b11; cyc(2);
    chk("R3", state_o, D3H, "field write to suspend");
    chk("R3", {clk_dis, mem_io_en, pm_status}, 4'b1011, "suspend gating");
    chk("R4", phy_pd, 0, "pd with pme set");
    chk("R4", n_prst - base, 0, "no phy reset with pme set");

    cur_req = "R9"; bus_rst_n = 1'b0; cyc(STG + 3);
    chk("R9", state_o, D3H, "bus reset ignored in suspend");
    bus_rst_n = 1'b1; cyc(STG + 3);

    cur_req = "R8"; base = n_exit;
    pm_field = 2'b00; cyc(3);
    chk("R8", state_o, D0U, "exit suspend");
    chk("R8", n_exit - base, 1, "exit pulse count");

    // Hot suspend with wake enable clear
    cur_req = "R4"; to_active(); base = n_prst; pme_en = 1'b0;
    pm_field = 2'b11; cyc(2);
    chk("R4", state_o, D3H, "suspend pme clear");
    chk("R4", phy_pd, 1, "pd with pme clear");
    chk("R4", n_prst - base, 1, "phy reset with pme clear");
    pme_en = 1'b1; pm_field = 2'b00; cyc(2);

    cur_req = "R5"; to_active();
    bus_rst_n = 1'b0; cyc(STG + 2);
    chk("R5", state_o, D0U, "bus reset to uninit");
    bus_rst_n = 1'b1; cyc(STG + 2);

    cur_req = "R6"; to_active(); base = n_prst;
    pwr_good = 1'b0; cyc(STG + 2);
    chk("R6", state_o, D3C, "pg fall aux on");
    chk("R6", phy_pd, 1, "cold pd");
    chk("R6", n_prst - base, 1, "cold phy reset");
    cur_req = "R10"; pwr_good = 1'b1; cyc(STG + 2);
    chk("R10", state_o, D0U, "cold to uninit on pg rise");

    cur_req = "R7"; to_active();
    aux_det = 1'b0; cyc(STG + 2);
    chk("R7", state_o, D0A, "aux drop alone no move");
    pwr_good = 1'b0; cyc(STG + 2);
    chk("R7", state_o, G3, "pg fall aux off");
    aux_det = 1'b1; pwr_good = 1'b1; cyc(STG + 2);
    chk("R10", state_o, D0U, "unpowered to uninit");

    to_active();
    aux_det = 1'b0; pwr_good = 1'b0; cyc(STG + 2);
    chk("R7", state_o, G3, "both supplies fall");
    chk("R7", {phy_pd, mem_io_en}, 2'b10, "unpowered outputs");
    aux_det = 1'b1; pwr_good = 1'b1; cyc(STG + 2);

    // Suspend, then pg falls with bus reset asserted
    cur_req = "R9"; to_active(); pm_field = 2'b11; cyc(2);
    bus_rst_n = 1'b0; pwr_good = 1'b0; cyc(STG + 2);
    chk("R9", state_o, D3C, "suspend to cold under bus reset");
    cur_req = "R10"; aux_det = 1'b0; cyc(STG + 2);
    chk("R10", state_o, G3, "cold to unpowered on aux drop");
    pm_field = 2'b00; bus_rst_n = 1'b1; aux_det = 1'b1; pwr_good = 1'b1; cyc(STG + 2);
    chk("R10", state_o, D0U, "recover after unpowered");

    // Priority and latency
    cur_req = "R11"; to_active();
    pwr_good = 1'b0; cyc(STG);
    chk("R12", state_o, D0A, "no move before sync latency");
    pm_field = 2'b11; cyc(1);
    chk("R11", state_o, D3C, "power fall beats host write");
    pm_field = 2'b00; pwr_good = 1'b1; cyc(STG + 2);
    chk("R11", state_o, D0U, "recover after priority test");

    cyc(4);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule